// File: doc/BRIEF.md
# Segmented multi-stream packet boundary tracker

This block watches a wide streaming input whose beats are 64 bytes, split into eight segments of eight bytes. It works out where packets begin and end, segment by segment. Each beat carries a 6-bit stream ID, a per-byte keep vector, a last flag and a per-segment end-marker vector. Beats from different streams may interleave at word granularity. Two packets of one stream may share a beat: the first ends in one segment, an all-empty segment follows, and the next packet begins after it.

For every accepted beat the block produces one registered output beat. That output beat carries per-segment start, end and idle flags, a valid-byte count for each segment, the stream ID, the data passed through unchanged, and one framing-error flag. A one-bit in-packet flag is kept for each of the 64 stream IDs. A stream's packet can therefore pause while other streams run and then resume on a later beat. The block only tags and checks framing. It does not modify, buffer or reassemble the payload.

Top module: `seg_frame_tracker`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and all 64 streams are outside a packet, so the first non-empty segment of any stream is tagged as a start.
- R2: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and it appears on the outputs after that edge with `out_valid` = 1. While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold.
- R3: Segment i (keep bits [8i+7:8i]) is non-empty when any of its keep bits is set. The first non-empty segment seen while its stream is outside a packet sets `out_sop[i]`, and the stream then counts as inside a packet. This state is kept per stream ID across interleaved beats of other streams.
- R4: `out_eop[i]` is 1 when segment i is non-empty and `in_eop_seg[i]` is 1, and the stream then leaves its packet. An end in segment 7 needs no idle segment after it.
- R5: `out_idle[i]` is 1 exactly when segment i has all-zero keep, and such a segment never carries start or end. `out_cnt[4i+3:4i]` is the number of set keep bits in segment i.
- R6: Within one beat, a non-empty segment that follows an idle segment after an end is tagged as the start of a new packet of the same stream.
- R7: `out_err` is 1 when `in_last` differs from the OR of `in_eop_seg`.
- R8: `out_err` is 1 when an end marker sits on a segment with all-zero keep. That marker produces no end, and the stream stays inside its packet.
- R9: `out_err` is 1 when a non-empty segment directly follows an end segment in the same beat. That segment is still tagged as a start.
- R10: `out_err` is 1 when a non-empty segment's keep is not a run of ones from byte 0, or when it is a partial run in a segment without an end marker.
- R11: `out_id` and `out_data` equal the `in_id` and `in_data` of the accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_id | input | 6 | Source stream ID |
| in_last | input | 1 | At least one packet ends in this beat |
| in_keep | input | 64 | Byte keep, eight bits per segment |
| in_eop_seg | input | 8 | Per-segment end marker |
| in_data | input | 512 | Beat payload |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_id | output | 6 | Stream ID of the output beat |
| out_data | output | 512 | Payload passed through |
| out_sop | output | 8 | Per-segment start of packet |
| out_eop | output | 8 | Per-segment end of packet |
| out_idle | output | 8 | Per-segment empty flag |
| out_cnt | output | 32 | Valid bytes per segment, four bits each |
| out_err | output | 1 | Framing error seen in this beat |

## Verification
The assertions take for granted that the downstream side does not rely on data while `out_valid` is low. They also assume that inputs are driven only between clock edges. They assume nothing about framing legality, because every illegal combination is defined to raise the error flag. The stimulus therefore mixes legal beats (continuations, ends at every segment with partial keep, two packets in one beat) with unconstrained random keep, marker and last values, across many stream IDs and with random back-pressure.

// File: rtl/sft_pkg.sv
// Package: shared default geometry for the segmented frame tracker.
// Assumes byte-wide keep and a power-of-two stream count.
package sft_pkg;
    localparam int SFT_SEGS      = 8;
    localparam int SFT_SEG_BYTES = 8;
    localparam int SFT_ID_W      = 6;
endpackage

// File: rtl/sft_seg_scan.sv
// Module: sft_seg_scan
// Purely combinational walk over the segments of one beat, from segment 0
// upward. It derives start/end/idle flags, per-segment byte counts, the
// stream's in-packet state after the beat, and a framing error.
// Assumes: keep is grouped SEG_BYTES bits per segment, byte 0 lowest.
module sft_seg_scan #(
    parameter int SEGS      = sft_pkg::SFT_SEGS,
    parameter int SEG_BYTES = sft_pkg::SFT_SEG_BYTES,
    parameter int CNT_W     = $clog2(SEG_BYTES + 1)
) (
    input  logic [SEGS*SEG_BYTES-1:0] keep,
    input  logic [SEGS-1:0]           mark,
    input  logic                      last,
    input  logic                      open_in,
    output logic [SEGS-1:0]           sop,
    output logic [SEGS-1:0]           eop,
    output logic [SEGS-1:0]           idle,
    output logic [SEGS*CNT_W-1:0]     cnt,
    output logic                      open_out,
    output logic                      err
);
    logic [SEGS:0]   st;      // in-packet state entering each segment
    logic [SEGS:0]   gap;     // previous segment carried an end
    logic [SEGS-1:0] e_gap;
    logic [SEGS-1:0] e_zmark;
    logic [SEGS-1:0] e_keep;

    assign st[0]  = open_in;
    assign gap[0] = 1'b0;

    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        logic [SEG_BYTES-1:0] k;
        logic kz, kfull, kcontig;
        assign k       = keep[i*SEG_BYTES +: SEG_BYTES];
        assign kz      = ~|k;
        assign kfull   = &k;
        assign kcontig = ((k & (k + 1'b1)) == '0);

        // Per-segment framing flags.
        always_comb begin
            idle[i]   = kz;
            sop[i]    = !kz && !st[i];
            eop[i]    = !kz && mark[i];
            st[i+1]   = kz ? st[i] : !mark[i];
            gap[i+1]  = !kz && mark[i];
            e_gap[i]  = !kz && gap[i];
            e_zmark[i]= kz && mark[i];
            e_keep[i] = !kz && (!kcontig || (!kfull && !mark[i]));
        end

        // Byte count of this segment.
        always_comb begin
            cnt[i*CNT_W +: CNT_W] = CNT_W'($countones(k));
        end
    end

    assign open_out = st[SEGS];
    assign err      = (|e_gap) | (|e_zmark) | (|e_keep) | (last != (|mark));
endmodule

// File: rtl/sft_stream_state.sv
// Module: sft_stream_state
// One in-packet flag per stream ID. Read is combinational; write is
// synchronous. Assumes a read and a write of one beat use the same ID.
module sft_stream_state #(
    parameter int ID_W     = sft_pkg::SFT_ID_W,
    parameter int NSTREAMS = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id,
    output logic            rd_open,
    input  logic            wr_en,
    input  logic            wr_open
);
    logic [NSTREAMS-1:0] open_q;

    assign rd_open = open_q[id];

    // Clear all streams on reset, record post-beat state on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else if (wr_en) begin
            open_q[id] <= wr_open;
        end
    end
endmodule

// File: rtl/sft_out_stage.sv
// Module: sft_out_stage
// Single register slice with valid/ready. Takes a new word when empty or
// when the held word leaves in the same cycle. Assumes no bypass is needed.
module sft_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_bus,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_bus
);
    assign in_ready = !out_valid || out_ready;

    // Valid flag: set on accept, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Payload: loaded on accept only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bus <= '0;
        end else if (in_valid && in_ready) begin
            out_bus <= in_bus;
        end
    end
endmodule

// File: rtl/seg_frame_tracker.sv
// Module: seg_frame_tracker
// Top of the segmented multi-stream packet boundary tracker. It looks up the
// beat's stream state, scans the segments, writes the state back on accept,
// and registers the tagged beat with one cycle of latency.
// Assumes: inputs are stable while in_valid is high and in_ready is low.
module seg_frame_tracker #(
    parameter int SEGS      = sft_pkg::SFT_SEGS,
    parameter int SEG_BYTES = sft_pkg::SFT_SEG_BYTES,
    parameter int ID_W      = sft_pkg::SFT_ID_W,
    localparam int KEEP_W   = SEGS * SEG_BYTES,
    localparam int DATA_W   = KEEP_W * 8,
    localparam int CNT_W    = $clog2(SEG_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [ID_W-1:0]       in_id,
    input  logic                  in_last,
    input  logic [KEEP_W-1:0]     in_keep,
    input  logic [SEGS-1:0]       in_eop_seg,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ID_W-1:0]       out_id,
    output logic [DATA_W-1:0]     out_data,
    output logic [SEGS-1:0]       out_sop,
    output logic [SEGS-1:0]       out_eop,
    output logic [SEGS-1:0]       out_idle,
    output logic [SEGS*CNT_W-1:0] out_cnt,
    output logic                  out_err
);
    localparam int BUS_W = ID_W + DATA_W + 3*SEGS + SEGS*CNT_W + 1;

    logic                  cur_open, nxt_open, scan_err, accept;
    logic [SEGS-1:0]       scan_sop, scan_eop, scan_idle;
    logic [SEGS*CNT_W-1:0] scan_cnt;
    logic [BUS_W-1:0]      bus_d, bus_q;

    assign accept = in_valid && in_ready;

    sft_stream_state #(.ID_W(ID_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .id      (in_id),
        .rd_open (cur_open),
        .wr_en   (accept),
        .wr_open (nxt_open)
    );

    sft_seg_scan #(.SEGS(SEGS), .SEG_BYTES(SEG_BYTES), .CNT_W(CNT_W)) u_scan (
        .keep     (in_keep),
        .mark     (in_eop_seg),
        .last     (in_last),
        .open_in  (cur_open),
        .sop      (scan_sop),
        .eop      (scan_eop),
        .idle     (scan_idle),
        .cnt      (scan_cnt),
        .open_out (nxt_open),
        .err      (scan_err)
    );

    assign bus_d = {in_id, in_data, scan_sop, scan_eop, scan_idle, scan_cnt, scan_err};

    sft_out_stage #(.W(BUS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bus    (bus_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bus   (bus_q)
    );

    assign {out_id, out_data, out_sop, out_eop, out_idle, out_cnt, out_err} = bus_q;

    // R2: a stalled output beat holds its contents.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_id)
                                    && $stable(out_sop) && $stable(out_err));

    // R2: an accepted beat is presented on the next cycle.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7: last flag disagreeing with the markers raises the error.
    a_r7_last_err: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_last != (|in_eop_seg)) |=> out_err);

    // R8: a marker on an empty segment raises the error.
    a_r8_zero_mark: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (|(scan_idle & in_eop_seg)) |=> out_err);

    // R5: an idle segment never carries start or end.
    a_r5_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_sop | out_eop) & out_idle) == '0));
endmodule

// File: tb/seg_frame_tracker_bench.sv
module seg_frame_tracker_bench;
    localparam int NDIR   = 19;
    localparam int NBEATS = 2500;

    typedef struct packed {
        logic [5:0]   id;
        logic [511:0] data;
        logic [7:0]   sop;
        logic [7:0]   eop;
        logic [7:0]   idle;
        logic [31:0]  cnt;
        logic         err;
        logic [7:0]   err_req;
        logic         two_pkt;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, in_last, out_valid, out_ready, out_err;
    logic [5:0]   in_id, out_id;
    logic [63:0]  in_keep;
    logic [7:0]   in_eop_seg, out_sop, out_eop, out_idle;
    logic [511:0] in_data, out_data;
    logic [31:0]  out_cnt;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [63:0] bst;
    exp_t q[$];

    always #5 clk = ~clk;

    seg_frame_tracker u_seg_frame_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_id(in_id), .in_last(in_last), .in_keep(in_keep), .in_eop_seg(in_eop_seg),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_id(out_id), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_idle(out_idle), .out_cnt(out_cnt), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input logic [511:0] act,
                         input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected tagging of one beat from the requirements; updates bench state.
    function automatic exp_t model(input logic [5:0] id, input logic last,
                                   input logic [63:0] keep, input logic [7:0] m,
                                   input logic [511:0] d);
        exp_t e;
        logic st, prev_end, seen_end;
        e = '0;
        e.id = id; e.data = d;
        st = bst[id]; prev_end = 0; seen_end = 0;
        if (last != (|m)) begin e.err = 1; e.err_req = 7; end
        for (int i = 0; i < 8; i++) begin
            logic [7:0] k;
            int n;
            k = keep[i*8 +: 8];
            n = $countones(k);
            e.cnt[i*4 +: 4] = 4'(n);
            if (k == 0) begin
                e.idle[i] = 1;
                if (m[i]) begin e.err = 1; e.err_req = 8; end
                prev_end = 0;
            end else begin
                if (!st) begin
                    e.sop[i] = 1;
                    if (seen_end) e.two_pkt = 1;
                end
                if (prev_end) begin e.err = 1; e.err_req = 9; end
                if (k != (8'hFF >> (8 - n)) || (n != 8 && !m[i])) begin
                    e.err = 1; e.err_req = 10;
                end
                if (m[i]) begin
                    e.eop[i] = 1; st = 0; prev_end = 1; seen_end = 1;
                end else begin
                    st = 1; prev_end = 0;
                end
            end
        end
        bst[id] = st;
        return e;
    endfunction

    function automatic logic [63:0] seg_fill(input logic [7:0] s0, s1, s2, s3, s4, s5, s6, s7);
        return {s7, s6, s5, s4, s3, s2, s1, s0};
    endfunction

    // Directed corner cases first, then constrained random beats.
    task automatic make_beat(input int idx);
        for (int w = 0; w < 16; w++) in_data[w*32 +: 32] = $urandom;
        in_keep = '1; in_eop_seg = 0; in_last = 0; in_id = 0;
        case (idx)
            0, 1, 3: ;                                   // R3 start then continuation
            2:  begin in_keep = seg_fill(8'hFF,8'hFF,8'hFF,8'hFF,8'h00,8'hFF,8'hFF,8'hFF);
                      in_eop_seg = 8'h08; in_last = 1; end  // R6 two packets
            4:  begin in_keep = seg_fill(8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'h00);
                      in_eop_seg = 8'h40; in_last = 1; end  // R4 end at seg 6
            5:  in_id = 0;
            6:  in_id = 2;
            7:  in_id = 3;
            8:  begin in_id = 2;
                      in_keep = seg_fill(8'hFF,8'hFF,8'hFF,8'hFF,8'h00,8'hFF,8'hFF,8'hFF);
                      in_eop_seg = 8'h08; in_last = 1; end
            9:  begin in_id = 0; in_eop_seg = 8'h80; in_last = 1; end  // R4 top end
            10: begin in_id = 3; in_eop_seg = 8'h80; in_last = 1; end
            11: begin in_id = 2; in_eop_seg = 8'h80; in_last = 1; end
            12: begin in_id = 5; in_last = 1; end                       // R7
            13: begin in_id = 5; in_eop_seg = 8'h80; end                // R7
            14: begin in_id = 6; in_keep[23:16] = 0;
                      in_eop_seg = 8'h04; in_last = 1; end              // R8
            15: begin in_id = 7; in_eop_seg = 8'h04; in_last = 1; end   // R9
            16: begin in_id = 8; in_keep[7:0] = 8'hF5; end              // R10
            17: begin in_id = 8; in_keep[15:8] = 8'h0F; end             // R10
            18: begin in_id = 9; in_keep = 64'h1;
                      in_eop_seg = 8'h01; in_last = 1; end              // R5 count 1
            default: begin
                int kind, k, c;
                in_id = ($urandom % 4 == 0) ? 6'($urandom % 64) : 6'($urandom % 6);
                kind = $urandom % 10;
                if (kind >= 5 && kind <= 7) begin
                    k = $urandom % 8; c = 1 + $urandom % 8;
                    in_keep[k*8 +: 8] = 8'hFF >> (8 - c);
                    for (int s = k + 1; s < 8; s++) in_keep[s*8 +: 8] = 0;
                    if (k <= 5 && ($urandom % 2 == 1))
                        for (int s = k + 2; s < 8; s++) in_keep[s*8 +: 8] = 8'hFF;
                    in_eop_seg = 8'(1 << k); in_last = 1;
                end else if (kind == 8) begin
                    in_keep = {$urandom, $urandom};
                    in_eop_seg = 8'($urandom); in_last = 1'($urandom);
                end else if (kind == 9) begin
                    in_eop_seg = 8'h80; in_last = 1'($urandom);
                end
            end
        endcase
    endtask

    initial begin
        exp_t e;
        int   idx;
        bit   taken, r;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; in_valid = 0; out_ready = 0; in_id = 0; in_last = 0;
        in_keep = 0; in_eop_seg = 0; in_data = 0; bst = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0, "R1 out_valid", 512'(out_valid), 0);
        check(in_ready == 1, "R1 in_ready", 512'(in_ready), 1);
        rst_n = 1;
        idx = 0; taken = 1;
        while (!done && (idx < NBEATS || q.size() != 0 || in_valid)) begin
            @(negedge clk);
            check(out_valid == (q.size() != 0), "R2 latency", 512'(out_valid),
                  512'(q.size() != 0));
            if (taken) begin
                if (idx < NBEATS && (idx < NDIR || $urandom % 8 != 0)) begin
                    make_beat(idx); in_valid = 1; idx++;
                end else begin
                    in_valid = 0;
                end
            end
            r = (idx <= NDIR + 1) ? 1'b1 : ($urandom % 4 != 0);
            if (out_valid && r && q.size() != 0) begin
                string rq;
                e = q.pop_front();
                rq = e.two_pkt ? "R6 sop" : "R3 sop";
                check(out_sop == e.sop, rq, 512'(out_sop), 512'(e.sop));
                check(out_eop == e.eop, "R4 eop", 512'(out_eop), 512'(e.eop));
                check(out_idle == e.idle, "R5 idle", 512'(out_idle), 512'(e.idle));
                check(out_cnt == e.cnt, "R5 cnt", 512'(out_cnt), 512'(e.cnt));
                rq = (e.err_req == 0) ? "R10 no-err" : $sformatf("R%0d err", e.err_req);
                check(out_err == e.err, rq, 512'(out_err), 512'(e.err));
                check(out_id == e.id, "R11 id", 512'(out_id), 512'(e.id));
                check(out_data == e.data, "R11 data", out_data, e.data);
            end
            out_ready = r;
            #1;
            if (out_valid && !r)
                check(in_ready == 0, "R2 stall", 512'(in_ready), 0);
            taken = !in_valid || in_ready;
            if (in_valid && in_ready)
                q.push_back(model(in_id, in_last, in_keep, in_eop_seg, in_data));
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule